// File: doc/BRIEF.md
# Iterative Non-Restoring Integer Divider

This unit divides one integer by another and returns both the quotient and the remainder. It handles signed and unsigned operands at two word sizes, 32-bit and 64-bit. It has no pipeline: it accepts one division, computes it over a fixed number of cycles, and presents the result before it accepts another. The core recurrence is non-restoring and retires exactly one quotient bit per cycle. Three extra cycles surround the recurrence: one for converting operands to magnitudes, one for the final remainder correction, and one for applying the result signs. The latency is therefore fixed at 35 cycles for 32-bit words and 67 cycles for 64-bit words. No operand values shorten it.

The caller pulses `start` together with the operands and the mode bits. `busy` then stays high until the result is ready. The result arrives with a one-cycle `done` pulse, and `quotient` and `remainder` keep their values until the next result replaces them. The unit ignores a `start` that arrives while `busy` is high.

Top module: `iter_divider`

## Requirements
- R1: In a cycle where `busy` is low, a `start` is accepted at the clock edge. `busy` is then high from the next cycle until the result is delivered.
- R2: In 32-bit mode (`wide`=0), `done` is high exactly 35 cycles after the edge that accepted `start`.
- R3: In 64-bit mode (`wide`=1), `done` is high exactly 67 cycles after the edge that accepted `start`.
- R4: `done` is high for a single cycle per division, and `busy` is low in that cycle. A new `start` may be accepted in that same cycle.
- R5: With `is_signed`=0, operands are treated as unsigned. The quotient is the floor of dividend/divisor and the remainder is dividend minus quotient times divisor.
- R6: With `is_signed`=1, operands are two's complement. The quotient truncates toward zero and a nonzero remainder carries the sign of the dividend.
- R7: A zero divisor takes the normal latency. It returns a quotient of all ones and a remainder equal to the dividend (sign-extended as in R8 for 32-bit mode).
- R8: In 32-bit mode only bits 31:0 of each operand are used, and bits 63:32 have no effect. Both results are sign-extended from bit 31 to 64 bits, also for unsigned division.
- R9: A `start` that arrives while `busy` is high is ignored. The running division keeps its latency and its result, and no extra result follows.
- R10: After reset `busy`, `done`, `quotient` and `remainder` are all zero. Between `done` pulses, `quotient` and `remainder` hold their values.
- R11: A signed division of the most negative value of the word size by -1 returns the dividend as the quotient and zero as the remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a division using the operands and mode bits of this cycle |
| is_signed | input | 1 | 1: two's-complement operands; 0: unsigned |
| wide | input | 1 | 1: 64-bit operation; 0: 32-bit operation on bits 31:0 |
| dividend | input | 64 | Dividend operand |
| divisor | input | 64 | Divisor operand |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: result valid and newly updated |
| quotient | output | 64 | Quotient of the latest completed division |
| remainder | output | 64 | Remainder of the latest completed division |

## Verification
Each internal fault in this divider shows up at the ports in a characteristic way. A miscounted iteration counter or a skipped phase moves the `done` pulse off its cycle, so it is caught in the very cycle of the expected completion. A wrong recurrence step, a skipped remainder correction or a wrong sign rule corrupts the quotient or remainder on that same `done` cycle. A state machine that starts again on a start that should be ignored leaves `busy` or `done` differing from the model within one cycle. The bench compares all four outputs on every clock against a behavioural model, using both fixed corner cases and varied operands.

// File: rtl/div_pkg.sv
// Package div_pkg: shared types of the iterative divider.
// Assumes: nothing beyond IEEE 1800-2017.
package div_pkg;

    // Sequencer phases of one division.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start request
        ST_CONV,   // operand magnitudes and result signs
        ST_ITER,   // one quotient bit per cycle
        ST_CORR,   // final remainder correction
        ST_FIX     // sign application, result delivery
    } div_state_t;

endpackage

// File: rtl/div_nr_step.sv
// div_nr_step: one non-restoring recurrence step, purely combinational.
// The partial remainder is held in two's complement, one bit wider than the
// divisor. The next dividend bit is taken from the top of the shift register,
// and the new quotient bit enters its bottom.
// Assumes: the divisor magnitude fits in XLEN bits and the partial remainder
// lies in [-divisor, divisor), so modular arithmetic keeps the result exact.
module div_nr_step #(
    parameter int XLEN = 64
) (
    input  logic [XLEN:0]   part_in,
    input  logic [XLEN-1:0] shreg_in,
    input  logic [XLEN-1:0] dsr,
    output logic [XLEN:0]   part_out,
    output logic [XLEN-1:0] shreg_out
);
    localparam int PW = XLEN + 1;

    logic [PW-1:0] shifted;

    // Shift the next dividend bit in, then add or subtract according to the sign.
    always_comb begin
        shifted  = {part_in[PW-2:0], shreg_in[XLEN-1]};
        if (part_in[PW-1]) begin
            part_out = shifted + {1'b0, dsr};
        end else begin
            part_out = shifted - {1'b0, dsr};
        end
        shreg_out = {shreg_in[XLEN-2:0], ~part_out[PW-1]};
    end

endmodule

// File: rtl/div_operand_prep.sv
// div_operand_prep: turns raw operands into unsigned magnitudes for the
// recurrence and works out the result signs.
// In narrow mode only the low half of each operand is used. The dividend
// magnitude is left-aligned so that the recurrence always reads from the top bit.
// Assumes: XLEN is even; inputs are stable while the sequencer samples them.
module div_operand_prep #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a_raw,
    input  logic [XLEN-1:0] b_raw,
    input  logic            sgn,
    input  logic            wide,
    output logic [XLEN-1:0] a_aligned,
    output logic [XLEN-1:0] b_mag,
    output logic            q_neg,
    output logic            r_neg,
    output logic            b_zero
);
    localparam int HALF = XLEN / 2;

    logic            a_sgn, b_sgn;
    logic [XLEN-1:0] a_n, b_n, a_abs, b_abs, a_mag;

    // Select the active width and take the absolute values.
    always_comb begin
        a_sgn = sgn & (wide ? a_raw[XLEN-1] : a_raw[HALF-1]);
        b_sgn = sgn & (wide ? b_raw[XLEN-1] : b_raw[HALF-1]);
        a_n   = wide ? a_raw : {{HALF{1'b0}}, a_raw[HALF-1:0]};
        b_n   = wide ? b_raw : {{HALF{1'b0}}, b_raw[HALF-1:0]};
        a_abs = a_sgn ? (~a_n + 1'b1) : a_n;
        b_abs = b_sgn ? (~b_n + 1'b1) : b_n;
        a_mag = wide ? a_abs : {{HALF{1'b0}}, a_abs[HALF-1:0]};
        b_mag = wide ? b_abs : {{HALF{1'b0}}, b_abs[HALF-1:0]};
        a_aligned = wide ? a_mag : {a_mag[HALF-1:0], {HALF{1'b0}}};
        q_neg  = a_sgn ^ b_sgn;
        r_neg  = a_sgn;
        b_zero = (b_n == '0);
    end

endmodule

// File: rtl/div_sign_fix.sv
// div_sign_fix: applies the result signs to the magnitudes, forces the
// quotient for a zero divisor, and sign-extends narrow results.
// Assumes: magnitudes already fit in the active width.
module div_sign_fix #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] q_mag,
    input  logic [XLEN-1:0] r_mag,
    input  logic            q_neg,
    input  logic            r_neg,
    input  logic            b_zero,
    input  logic            wide,
    output logic [XLEN-1:0] q_out,
    output logic [XLEN-1:0] r_out
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] q_s, r_s;

    // Negate where needed, override on a zero divisor, then widen.
    always_comb begin
        q_s = q_neg ? (~q_mag + 1'b1) : q_mag;
        r_s = r_neg ? (~r_mag + 1'b1) : r_mag;
        if (b_zero) begin
            q_s = '1;
        end
        q_out = wide ? q_s : {{HALF{q_s[HALF-1]}}, q_s[HALF-1:0]};
        r_out = wide ? r_s : {{HALF{r_s[HALF-1]}}, r_s[HALF-1:0]};
    end

endmodule

// File: rtl/iter_divider.sv
// iter_divider: unpipelined integer divider that produces a quotient and a
// remainder, signed or unsigned, on full or half words. It sequences capture,
// conversion, XLEN or XLEN/2 non-restoring steps, correction and sign fix-up,
// so the latency is the step count plus three cycles.
// Assumes: synchronous active-low reset; start is ignored while busy.
module iter_divider #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            is_signed,
    input  logic            wide,
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] quotient,
    output logic [XLEN-1:0] remainder
);
    import div_pkg::*;

    localparam int HALF = XLEN / 2;
    localparam int PW   = XLEN + 1;
    localparam int CW   = $clog2(XLEN + 1);
    localparam int LW   = $clog2(XLEN + 4) + 1;

    div_state_t      state;
    logic [XLEN-1:0] a_raw, b_raw;
    logic            sgn_r, wide_r;
    logic [XLEN-1:0] shreg, dsr;
    logic [PW-1:0]   part;
    logic [CW-1:0]   iter;
    logic            qneg_r, rneg_r, bz_r;

    logic [XLEN-1:0] a_aligned, b_mag;
    logic            q_neg, r_neg, b_zero;
    logic [PW-1:0]   part_nx;
    logic [XLEN-1:0] shreg_nx;
    logic [XLEN-1:0] q_fix, r_fix;

    div_operand_prep #(.XLEN(XLEN)) u_prep (
        .a_raw     (a_raw),
        .b_raw     (b_raw),
        .sgn       (sgn_r),
        .wide      (wide_r),
        .a_aligned (a_aligned),
        .b_mag     (b_mag),
        .q_neg     (q_neg),
        .r_neg     (r_neg),
        .b_zero    (b_zero)
    );

    div_nr_step #(.XLEN(XLEN)) u_step (
        .part_in   (part),
        .shreg_in  (shreg),
        .dsr       (dsr),
        .part_out  (part_nx),
        .shreg_out (shreg_nx)
    );

    div_sign_fix #(.XLEN(XLEN)) u_fix (
        .q_mag  (shreg),
        .r_mag  (part[XLEN-1:0]),
        .q_neg  (qneg_r),
        .r_neg  (rneg_r),
        .b_zero (bz_r),
        .wide   (wide_r),
        .q_out  (q_fix),
        .r_out  (r_fix)
    );

    // Busy covers every phase except idle.
    assign busy = (state != ST_IDLE);

    // Sequencer and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            a_raw     <= '0;
            b_raw     <= '0;
            sgn_r     <= 1'b0;
            wide_r    <= 1'b0;
            shreg     <= '0;
            dsr       <= '0;
            part      <= '0;
            iter      <= '0;
            qneg_r    <= 1'b0;
            rneg_r    <= 1'b0;
            bz_r      <= 1'b0;
            done      <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        a_raw  <= dividend;
                        b_raw  <= divisor;
                        sgn_r  <= is_signed;
                        wide_r <= wide;
                        state  <= ST_CONV;
                    end
                end
                ST_CONV: begin
                    shreg  <= a_aligned;
                    dsr    <= b_mag;
                    part   <= '0;
                    qneg_r <= q_neg;
                    rneg_r <= r_neg;
                    bz_r   <= b_zero;
                    iter   <= wide_r ? CW'(XLEN) : CW'(HALF);
                    state  <= ST_ITER;
                end
                ST_ITER: begin
                    part  <= part_nx;
                    shreg <= shreg_nx;
                    iter  <= iter - 1'b1;
                    if (iter == CW'(1)) begin
                        state <= ST_CORR;
                    end
                end
                ST_CORR: begin
                    if (part[PW-1]) begin
                        part <= part + {1'b0, dsr};
                    end
                    state <= ST_FIX;
                end
                ST_FIX: begin
                    quotient  <= q_fix;
                    remainder <= r_fix;
                    done      <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Independent cycle counter: edges since the accepting edge, used by checks.
    logic [LW-1:0] lat_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '0;
        end else if (!busy && start) begin
            lat_cnt <= '0;
        end else if (busy) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    // R2 and R3: the result appears exactly step count plus three after acceptance.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == (wide_r ? LW'(XLEN + 3) : LW'(HALF + 3))));

    // R4: done is a single-cycle pulse and never overlaps busy.
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R1: an idle start makes busy high on the next cycle.
    p_start_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R9: a start during a division leaves the captured request unchanged.
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(a_raw) && $stable(b_raw) && $stable(wide_r)));

    // R10: results hold between done pulses.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && $past(rst_n)) |-> ($stable(quotient) && $stable(remainder)));

    // R7: zero divisor yields an all-ones quotient.
    p_div_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && bz_r) |-> (quotient == '1));

endmodule

// File: tb/iter_divider_test.sv
// iter_divider_test: drives directed and varied divisions and compares every
// output each clock with a behavioural cycle model.
module iter_divider_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic        wide = 1'b0;
    logic [63:0] dividend = '0;
    logic [63:0] divisor = '0;
    logic        busy, done;
    logic [63:0] quotient, remainder;

    int checks = 0;
    int fails = 0;
    string cur_tag = "R10";

    iter_divider #(.XLEN(64)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .wide(wide), .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient), .remainder(remainder)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Behavioural reference.
    logic        m_busy = 1'b0, m_done = 1'b0, m_wide = 1'b0;
    int          m_cnt = 0;
    logic [63:0] m_q = '0, m_r = '0, p_q = '0, p_r = '0;

    task automatic ref_div(input logic [63:0] a, input logic [63:0] b, input logic s,
                           input logic w, output logic [63:0] q, output logic [63:0] r);
        if (!w) begin
            logic [31:0] a32, b32, q32, r32;
            a32 = a[31:0];
            b32 = b[31:0];
            if (b32 == 0) begin
                q32 = '1; r32 = a32;
            end else if (s && a32 == 32'h8000_0000 && b32 == 32'hFFFF_FFFF) begin
                q32 = a32; r32 = 0;
            end else if (s) begin
                int sa, sb;
                sa = a32; sb = b32;
                q32 = sa / sb; r32 = sa % sb;
            end else begin
                q32 = a32 / b32; r32 = a32 % b32;
            end
            q = {{32{q32[31]}}, q32};
            r = {{32{r32[31]}}, r32};
        end else begin
            if (b == 0) begin
                q = '1; r = a;
            end else if (s && a == 64'h8000_0000_0000_0000 && b == '1) begin
                q = a; r = 0;
            end else if (s) begin
                longint sa, sb;
                sa = a; sb = b;
                q = sa / sb; r = sa % sb;
            end else begin
                q = a / b; r = a % b;
            end
        end
    endtask

    // Model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0; m_q = 0; m_r = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (m_cnt == 1) begin
                    m_busy = 0; m_done = 1; m_q = p_q; m_r = p_r;
                end else begin
                    m_cnt--;
                end
            end else if (start) begin
                m_busy = 1;
                m_wide = wide;
                m_cnt  = wide ? 67 : 35;
                ref_div(dividend, divisor, is_signed, wide, p_q, p_r);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy === m_busy, "R1", 64'(busy), 64'(m_busy));
            chk(done === m_done, m_wide ? "R3 R4" : "R2 R4", 64'(done), 64'(m_done));
            chk(quotient === m_q, cur_tag, quotient, m_q);
            chk(remainder === m_r, cur_tag, remainder, m_r);
        end
    end

    task automatic run(input logic [63:0] a, input logic [63:0] b, input logic s,
                       input logic w, input string tag);
        @(negedge clk);
        cur_tag = tag;
        dividend = a; divisor = b; is_signed = s; wide = w; start = 1;
        @(negedge clk);
        start = 0;
        while (!m_done) @(negedge clk);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values.
        chk(busy === 0 && done === 0, "R10", 64'({busy, done}), 64'(0));
        chk(quotient === 0 && remainder === 0, "R10", quotient | remainder, 64'(0));
        rst_n = 1;
        // R5 unsigned 64-bit.
        run(64'd100, 64'd7, 0, 1, "R5");
        run('1, 64'd3, 0, 1, "R5");
        run(64'd5, 64'd10, 0, 1, "R5");
        run('1, '1, 0, 1, "R5");
        // R6 signed truncation.
        run(-64'sd7, 64'sd2, 1, 1, "R6");
        run(64'sd7, -64'sd2, 1, 1, "R6");
        run(-64'sd7, -64'sd2, 1, 1, "R6");
        // R11 overflow case in both sizes.
        run(64'h8000_0000_0000_0000, '1, 1, 1, "R11");
        run(64'hDEAD_0000_8000_0000, 64'h1234_5678_FFFF_FFFF, 1, 0, "R11");
        // R7 zero divisor.
        run(-64'sd12345, 64'd0, 1, 1, "R7");
        run(64'h0000_0001_8000_0005, 64'hFFFF_0000_0000_0000, 0, 0, "R7");
        // R8 narrow mode: upper bits ignored, results sign-extended.
        run(64'hABCD_EF01_FFFF_FFF0, 64'h5555_5555_0000_0003, 0, 0, "R8");
        run(64'h1111_1111_FFFF_FF9C, 64'h2222_2222_0000_0007, 1, 0, "R8");
        // R9: starts while busy are ignored.
        @(negedge clk);
        cur_tag = "R9";
        dividend = 64'd1000; divisor = 64'd9; is_signed = 0; wide = 1; start = 1;
        @(negedge clk);
        dividend = 64'd5; divisor = 64'd1; wide = 0;
        repeat (4) @(negedge clk);
        start = 0;
        while (!m_done) @(negedge clk);
        repeat (3) @(negedge clk);
        // Varied operands across all modes.
        for (int i = 0; i < 24; i++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom} >> (i % 60);
            run(a, b, i[0], i[1], i[1] ? "R5 R6" : "R8");
        end
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule